// File: doc/BRIEF.md
# Handshake Clock-Crossing Field Write Path

This block carries a write from hardware logic in one clock domain into a register field that sits in a second, asynchronous clock domain. It does not depend on sampling luck. When the hardware side pulses its write enable, the block captures the data and raises a busy flag. It then runs a four-phase request/acknowledge exchange with the field domain. The busy flag drops only once that exchange has fully closed. A producer that waits for busy to fall before issuing the next write therefore never loses a value, even when its clock is faster than the field clock.

The request crosses into the field domain through a two-flop synchronizer. Its rising edge in the field domain loads the captured data into the field flops exactly once. The field domain echoes the synchronized request back as an acknowledge. The acknowledge returns through a second two-flop synchronizer. The hardware-side state machine lowers the request when the acknowledge arrives. It clears busy when the acknowledge has fallen again. Each domain has its own synchronous active-low reset.

Top module: `cdc_hs_field_wr`

## Requirements
- R1: After both resets, `wr_busy` is 0 and `field_val` equals the parameter `RESET_VAL`.
- R2: A `wr_en` high at a source clock edge while `wr_busy` is low makes `wr_busy` read 1 after that same edge.
- R3: The value of `wr_data` sampled together with an accepted `wr_en` appears on `field_val`.
- R4: `wr_busy` stays high until the request has been acknowledged and the acknowledge has fallen again. By the time `wr_busy` reads 0, `field_val` already holds the written value.
- R5: A `wr_en` that arrives while `wr_busy` is high is ignored. It does not change the value written, and it does not start a further exchange once busy clears.
- R6: Changes on `wr_data` while `wr_busy` is high have no effect on the value stored in the field.
- R7: The field is loaded exactly once per exchange, on the rising edge of the synchronized request. At all other times it holds its value.
- R8: Back-to-back writes from a source clock faster than the field clock, each issued as soon as busy falls, all reach the field in order with none dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Hardware-side (sending) clock |
| src_rst_n | input | 1 | Synchronous active-low reset, source domain |
| fld_clk | input | 1 | Register-field clock |
| fld_rst_n | input | 1 | Synchronous active-low reset, field domain |
| wr_en | input | 1 | Write strobe, source domain |
| wr_data | input | DATA_W | Write value, source domain |
| wr_busy | output | 1 | High while an exchange is in flight |
| field_val | output | DATA_W | Stored field value, field domain |

## Verification
The assertions assume that the producer only starts a write while busy is low. They also assume that both resets are held long enough to cover several edges of both clocks. Under those assumptions the request holds until the acknowledge is seen, the captured data stays frozen for the whole exchange, and the field only moves on a load. The stimulus is driven on source clock falling edges. It waits for busy to fall before each legal write. Its out-of-protocol strobes and data changes are confined to windows where busy is known to be high, which is exactly the case that R5 and R6 describe.

// File: rtl/cdc_hs_pkg.sv
// Package: shared types for the handshake field-write crossing.
// Assumes: nothing; types only.
package cdc_hs_pkg;
    typedef enum logic [1:0] {
        HS_IDLE = 2'd0,
        HS_REQ  = 2'd1,
        HS_DROP = 2'd2
    } hs_state_e;
endpackage

// File: rtl/cdc_hs_sync.sv
// Module: multi-flop level synchronizer for a single bit.
// Assumes: input is a glitch-free flop output from another domain.
module cdc_hs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_async};
    end

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/cdc_hs_src.sv
// Module: source-domain control for the four-phase write exchange.
// Captures data on an accepted strobe, drives the request, and clears
// busy once the synchronized acknowledge has risen and fallen.
// Assumes: ack_sync is already synchronized to clk.
module cdc_hs_src
    import cdc_hs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ack_sync,
    output logic              busy,
    output logic              req,
    output logic [DATA_W-1:0] hold_data
);
    hs_state_e   state_q;
    logic        req_q;
    logic [DATA_W-1:0] hold_q;

    // Advance the exchange state machine and its request flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= HS_IDLE;
            req_q   <= 1'b0;
        end else begin
            case (state_q)
                HS_IDLE: if (wr_en) begin
                    state_q <= HS_REQ;
                    req_q   <= 1'b1;
                end
                HS_REQ: if (ack_sync) begin
                    state_q <= HS_DROP;
                    req_q   <= 1'b0;
                end
                HS_DROP: if (!ack_sync) state_q <= HS_IDLE;
                default: begin
                    state_q <= HS_IDLE;
                    req_q   <= 1'b0;
                end
            endcase
        end
    end

    // Capture write data only when a new exchange is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)                          hold_q <= '0;
        else if (state_q == HS_IDLE && wr_en) hold_q <= wr_data;
    end

    assign busy      = (state_q != HS_IDLE);
    assign req       = req_q;
    assign hold_data = hold_q;

    // R2
    busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_en) |=> busy);
    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack_sync) |=> req);
    // R6
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(hold_data));
endmodule

// File: rtl/cdc_hs_dst.sv
// Module: field-domain side; loads the field on the rising edge of the
// synchronized request and echoes the request back as acknowledge.
// Assumes: req_sync is synchronized to clk; hold_data is frozen while
// the request is high.
module cdc_hs_dst #(
    parameter int              DATA_W    = 8,
    parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_sync,
    input  logic [DATA_W-1:0] hold_data,
    output logic              ack,
    output logic [DATA_W-1:0] field
);
    logic              req_d_q;
    logic              ack_q;
    logic [DATA_W-1:0] field_q;
    logic              load;

    assign load = req_sync && !req_d_q;

    // Track the previous request level and return it as acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_d_q <= 1'b0;
            ack_q   <= 1'b0;
        end else begin
            req_d_q <= req_sync;
            ack_q   <= req_sync;
        end
    end

    // Load the field flops once per exchange.
    always_ff @(posedge clk) begin
        if (!rst_n)    field_q <= RESET_VAL;
        else if (load) field_q <= hold_data;
    end

    assign ack   = ack_q;
    assign field = field_q;

    // R7
    field_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(field));
endmodule

// File: rtl/cdc_hs_field_wr.sv
// Module: top of the handshake write path into a field in another clock
// domain. Request and acknowledge each cross through their own synchronizer.
// Assumes: the producer issues wr_en only while wr_busy is low.
module cdc_hs_field_wr #(
    parameter int              DATA_W      = 8,
    parameter logic [DATA_W-1:0] RESET_VAL = '0,
    parameter int              SYNC_STAGES = 2
) (
    input  logic              src_clk,
    input  logic              src_rst_n,
    input  logic              fld_clk,
    input  logic              fld_rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_busy,
    output logic [DATA_W-1:0] field_val
);
    logic              req;
    logic              req_sync;
    logic              ack;
    logic              ack_sync;
    logic [DATA_W-1:0] hold_data;

    cdc_hs_src #(.DATA_W(DATA_W)) u_src (
        .clk(src_clk), .rst_n(src_rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .ack_sync(ack_sync), .busy(wr_busy), .req(req), .hold_data(hold_data)
    );

    cdc_hs_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk(fld_clk), .rst_n(fld_rst_n), .d_async(req), .q_sync(req_sync)
    );

    cdc_hs_dst #(.DATA_W(DATA_W), .RESET_VAL(RESET_VAL)) u_dst (
        .clk(fld_clk), .rst_n(fld_rst_n), .req_sync(req_sync),
        .hold_data(hold_data), .ack(ack), .field(field_val)
    );

    cdc_hs_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk(src_clk), .rst_n(src_rst_n), .d_async(ack), .q_sync(ack_sync)
    );
endmodule

// File: tb/cdc_hs_field_wr_bench.sv
module cdc_hs_field_wr_bench;
    localparam int          W     = 4;
    localparam logic [W-1:0] RSTV = 4'hA;

    logic src_clk = 1'b0, fld_clk = 1'b0;
    logic src_rst_n = 1'b0, fld_rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic wr_busy;
    logic [W-1:0] field_val;

    int tests = 0, fails = 0, changes = 0;
    logic [W-1:0] prev_field;
    logic track = 1'b0;

    always #10 src_clk = ~src_clk;   // 50 MHz source clock
    always #27 fld_clk = ~fld_clk;   // slower field clock

    cdc_hs_field_wr #(.DATA_W(W), .RESET_VAL(RSTV), .SYNC_STAGES(2)) u_cdc_hs_field_wr (
        .src_clk(src_clk), .src_rst_n(src_rst_n), .fld_clk(fld_clk),
        .fld_rst_n(fld_rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_busy(wr_busy), .field_val(field_val)
    );

    // Count field changes away from the field clock edge (R7).
    always @(negedge fld_clk) begin
        if (track && field_val !== prev_field) changes++;
        prev_field <= field_val;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic start_write(input logic [W-1:0] v);
        @(negedge src_clk);
        wr_en = 1'b1; wr_data = v;
        @(negedge src_clk);
        wr_en = 1'b0;
        check("R2 busy after strobe", wr_busy, 1);
    endtask

    task automatic wait_idle();
        int n = 0;
        while (wr_busy && n < 500) begin
            @(negedge src_clk);
            n++;
        end
        if (n >= 500) check("R4 watchdog busy stuck", 1, 0);
    endtask

    initial begin
        #2000000;
        fails++; tests++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int base;
        repeat (6) @(negedge fld_clk);
        src_rst_n = 1'b1; fld_rst_n = 1'b1;
        @(negedge src_clk);
        // R1 reset state
        check("R1 busy after reset", wr_busy, 0);
        check("R1 field reset value", field_val, RSTV);
        prev_field = field_val;
        track = 1'b1;
        // R3 R4 R7 R8: full sweep, back-to-back, each differs from previous
        for (int v = 0; v < 16; v++) begin
            base = changes;
            start_write(W'(v));
            wait_idle();
            check("R3 R4 field when busy falls", field_val, v);
            check("R7 one load per exchange", changes - base, 1);
        end
        check("R8 all writes captured", changes, 16);
        // R5 R6: extra strobes and data churn during busy
        base = changes;
        start_write(4'h5);
        for (int k = 0; k < 3; k++) begin
            @(negedge src_clk);
            wr_en = 1'b1; wr_data = W'(4'hC + k);
            @(negedge src_clk);
            wr_en = 1'b0; wr_data = 4'h9;
        end
        wait_idle();
        check("R5 R6 field keeps first value", field_val, 4'h5);
        for (int k = 0; k < 4; k++) begin
            @(negedge src_clk);
            check("R5 no restarted exchange", wr_busy, 0);
        end
        repeat (10) @(negedge fld_clk);
        check("R5 R7 single load despite strobes", changes - base, 1);
        check("R5 field unchanged later", field_val, 4'h5);
        // R7: rewriting the same value leaves field stable
        base = changes;
        start_write(4'h5);
        wait_idle();
        check("R7 same value no change", changes - base, 0);
        check("R3 same value held", field_val, 4'h5);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule